// File: doc/BRIEF.md
# Grouped Sticky Interrupt Aggregator

This block gathers single-cycle event pulses from many peripheral sources and folds them into five grouped interrupt lines, each with a fixed vector number for the CPU interrupt controller. Every group owns a sticky request register with seven flags, an enable register with seven per-source enables and a group-use bit, and a control register that holds the group's interrupt-pending flag. The request flags latch events and are never cleared by hardware. Only a software write clears them, and that write affects only the bits written as 0.

The pending flag of a group is set on a rising edge of the group's combined request. The combined request is the use bit ANDed with the OR of all enabled request flags. It is not set on the level. As a result, a flag that software leaves set holds the combined request high, and later events in that group raise no new interrupt until software clears the flags. The pending flag is dropped by a per-group acknowledge input or by a software write of 0. A small address/data port with a write strobe and combinational read data gives software access to all fifteen registers.

Top module: `grp_irq_agg`

## Requirements
- R1: A synchronous active-high `rst` clears every request, enable and pending flag, so that all reads return 0 and `irq_o` is 0.
- R2: A pulse on `evt_i[g*7+j]` sets request bit j+1 of group g at that clock edge. Request bits 7..1 are sticky, bit 0 always reads 0, and an acknowledge does not clear them.
- R3: A write to a request register clears each bit written as 0 and keeps each bit written as 1. A write never sets a bit. When an event and a clearing write hit the same bit in the same cycle, the bit ends at 1.
- R4: The pending flag of group g rises when the combined request goes from 0 to 1. The combined request is use bit AND OR(request[7:1] AND enable[7:1]). For an event pulse applied in cycle k, `irq_o[g]` is first high after the edge that ends cycle k+1. Groups act independently.
- R5: With the use bit at 0, or with the source's enable bit at 0, an event sets no pending flag.
- R6: While the combined request stays at 1, further events in that group create no new pending flag, including after an acknowledge.
- R7: The pending flag clears on `ack_i[g]` or on a write of 0 to control bit 0. A write of 1 has no effect. A rising edge in the same cycle as a clear leaves the flag at 1.
- R8: `irq_vec_o[g*8 +: 8]` carries the constant vector number 44+g.
- R9: The register address is {group[2:0], select[1:0]}. Select 0 is the request register, 1 the enable register (bit 0 use, bit j+1 enables source j) and 2 the control register (bit 0 pending, other bits 0). Select 3 and groups 5 to 7 read 0 and ignore writes.
- R10: An enable write stores all eight bits, which read back unchanged. A single write that changes both the use bit and any source enable is illegal and is flagged by an assertion.
- R11: Setting the use bit or a source enable while a matching request flag is already 1 raises the combined request and so sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 35 | Event pulses, source j of group g at bit g*7+j |
| ack_i | input | 5 | Per-group acknowledge, clears the pending flag |
| reg_addr_i | input | 5 | Register address {group, select} |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 5 | Per-group pending flags toward the interrupt controller |
| irq_vec_o | output | 40 | Per-group vector numbers, 8 bits each |

## Verification
Two pairs of functions can fall in the same cycle, and the bench drives each pair into one cycle on purpose. In the first pair, an event pulse and a clearing write land on the same request bit while that bit is already 1; the bench reads the register afterwards and expects the bit to be kept. In the second pair, a combined-request rising edge meets an acknowledge for the same group, with the edge arranged by clearing the flags and then pulsing one event a cycle before the acknowledge. The bench expects the pending line to stay high and then to fall on a later, lone acknowledge.

// File: rtl/grp_irq_pkg.sv
`timescale 1ns/1ps
package grp_irq_pkg;

   // low two address bits select the register inside a group
   typedef enum logic [1:0] {
      SEL_REQ  = 2'd0,
      SEL_EN   = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int SEL_W = 2;

   // address width needed for a group index
   function automatic int grp_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/grp_req_bank.sv
`timescale 1ns/1ps
module grp_req_bank #(
   parameter int SRC_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SRC_W-1:0] evt_i,
   input  logic             wr_i,
   input  logic [SRC_W-1:0] keep_i,
   output logic [SRC_W-1:0] req_o
);

   logic [SRC_W-1:0] req_q;
   logic [SRC_W-1:0] req_d;

   // software may only clear; a same-cycle event re-sets the bit
   always_comb begin
      if (wr_i) req_d = (req_q & keep_i) | evt_i;
      else      req_d = req_q | evt_i;
   end

   always_ff @(posedge clk) begin
      if (rst) req_q <= '0;
      else     req_q <= req_d;
   end

   assign req_o = req_q;

   for (genvar b = 0; b < SRC_W; b++) begin : g_bit_chk
      AST_REQ_ONLY_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
         $fell(req_q[b]) |-> $past(wr_i && !keep_i[b]));   // R3
      AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (rst)
         evt_i[b] |=> req_q[b]);                            // R2
      AST_WRITE_NO_SET: assert property (@(posedge clk) disable iff (rst)
         $rose(req_q[b]) |-> $past(evt_i[b]));              // R3
   end

endmodule

// File: rtl/grp_irq_lane.sv
`timescale 1ns/1ps
module grp_irq_lane #(
   parameter  int SRC_W          = 7,
   parameter  bit SET_OVER_CLEAR = 1'b1,
   localparam int DATA_W         = SRC_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SRC_W-1:0]  req_i,
   input  logic              en_wr_i,
   input  logic              ctl_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              ack_i,
   output logic [DATA_W-1:0] en_o,
   output logic              ir_o
);

   logic             use_q;
   logic [SRC_W-1:0] src_en_q;
   logic             comb;
   logic             comb_q;
   logic             rise;
   logic             clr;
   logic             ir_d;
   logic             ir_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         use_q    <= 1'b0;
         src_en_q <= '0;
      end else if (en_wr_i) begin
         use_q    <= wdata_i[0];
         src_en_q <= wdata_i[DATA_W-1:1];
      end
   end

   assign comb = use_q & (|(req_i & src_en_q));
   assign rise = comb & ~comb_q;
   assign clr  = ack_i | (ctl_wr_i & ~wdata_i[0]);

   // priority between a fresh edge and a clear in the same cycle
   if (SET_OVER_CLEAR) begin : g_set_wins
      assign ir_d = rise | (ir_q & ~clr);
   end else begin : g_clr_wins
      assign ir_d = (rise | ir_q) & ~clr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         comb_q <= 1'b0;
         ir_q   <= 1'b0;
      end else begin
         comb_q <= comb;
         ir_q   <= ir_d;
      end
   end

   assign en_o = {src_en_q, use_q};
   assign ir_o = ir_q;

   AST_IR_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
      $rose(ir_q) |-> $past(comb && !comb_q));                         // R4
   AST_NO_USE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
      !use_q |=> !$rose(ir_q));                                        // R5
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
      (comb_q && comb && !ir_q) |=> !ir_q);                            // R6
   AST_IR_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (ir_q && clr && !rise) |=> !ir_q);                               // R7
   AST_IR_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (ir_q && !clr) |=> ir_q);                                        // R7
   AST_USE_EN_SPLIT: assert property (@(posedge clk) disable iff (rst)
      en_wr_i |-> !((wdata_i[0] != use_q) &&
                    (wdata_i[DATA_W-1:1] != src_en_q)));               // R10

endmodule

// File: rtl/grp_reg_port.sv
`timescale 1ns/1ps
module grp_reg_port
   import grp_irq_pkg::*;
#(
   parameter  int NUM_GRP = 5,
   parameter  int SRC_W   = 7,
   localparam int DATA_W  = SRC_W + 1,
   localparam int GRP_AW  = grp_idx_w(NUM_GRP),
   localparam int ADDR_W  = GRP_AW + SEL_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic                      we_i,
   input  logic [NUM_GRP*SRC_W-1:0]  req_flat_i,
   input  logic [NUM_GRP*DATA_W-1:0] en_flat_i,
   input  logic [NUM_GRP-1:0]        ir_i,
   output logic [NUM_GRP-1:0]        wr_req_o,
   output logic [NUM_GRP-1:0]        wr_en_o,
   output logic [NUM_GRP-1:0]        wr_ctl_o,
   output logic [DATA_W-1:0]         rdata_o
);

   reg_sel_e          sel;
   logic [GRP_AW-1:0] gidx;

   assign sel  = reg_sel_e'(addr_i[SEL_W-1:0]);
   assign gidx = addr_i[ADDR_W-1:SEL_W];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_strobe
      logic hit;
      assign hit         = we_i && (gidx == GRP_AW'(g));
      assign wr_req_o[g] = hit && (sel == SEL_REQ);
      assign wr_en_o[g]  = hit && (sel == SEL_EN);
      assign wr_ctl_o[g] = hit && (sel == SEL_CTL);
   end

   always_comb begin
      rdata_o = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (gidx == GRP_AW'(g)) begin
            case (sel)
               SEL_REQ: rdata_o = {req_flat_i[g*SRC_W +: SRC_W], 1'b0};
               SEL_EN:  rdata_o = en_flat_i[g*DATA_W +: DATA_W];
               SEL_CTL: rdata_o = DATA_W'(ir_i[g]);
               default: rdata_o = '0;
            endcase
         end
      end
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
      $onehot0({wr_req_o, wr_en_o, wr_ctl_o}));                        // R9
   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !we_i |-> ({wr_req_o, wr_en_o, wr_ctl_o} == '0));                // R9

endmodule

// File: rtl/grp_irq_agg.sv
`timescale 1ns/1ps
module grp_irq_agg
   import grp_irq_pkg::*;
#(
   parameter  int NUM_GRP        = 5,
   parameter  int SRC_W          = 7,
   parameter  int VEC_W          = 8,
   parameter  int VEC_BASE       = 44,
   parameter  bit SET_OVER_CLEAR = 1'b1,
   localparam int DATA_W         = SRC_W + 1,
   localparam int GRP_AW         = grp_idx_w(NUM_GRP),
   localparam int ADDR_W         = GRP_AW + SEL_W,
   localparam int EVT_W          = NUM_GRP * SRC_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [EVT_W-1:0]         evt_i,
   input  logic [NUM_GRP-1:0]       ack_i,
   input  logic [ADDR_W-1:0]        reg_addr_i,
   input  logic                     reg_we_i,
   input  logic [DATA_W-1:0]        reg_wdata_i,
   output logic [DATA_W-1:0]        reg_rdata_o,
   output logic [NUM_GRP-1:0]       irq_o,
   output logic [NUM_GRP*VEC_W-1:0] irq_vec_o
);

   // elaboration-time parameter checks
   if (NUM_GRP < 1) begin : g_bad_grp
      $error("NUM_GRP must be at least 1");
   end
   if (SRC_W < 1 || SRC_W > 31) begin : g_bad_src
      $error("SRC_W must lie in 1..31");
   end
   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vw
      $error("VEC_W must lie in 1..16");
   end
   if (VEC_BASE < 0 || (VEC_BASE + NUM_GRP - 1) >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector numbers do not fit in VEC_W bits");
   end

   logic [NUM_GRP*SRC_W-1:0]  req_flat;
   logic [NUM_GRP*DATA_W-1:0] en_flat;
   logic [NUM_GRP-1:0]        ir_vec;
   logic [NUM_GRP-1:0]        wr_req;
   logic [NUM_GRP-1:0]        wr_en;
   logic [NUM_GRP-1:0]        wr_ctl;

   grp_reg_port #(
      .NUM_GRP (NUM_GRP),
      .SRC_W   (SRC_W)
   ) u_port (
      .clk        (clk),
      .rst        (rst),
      .addr_i     (reg_addr_i),
      .we_i       (reg_we_i),
      .req_flat_i (req_flat),
      .en_flat_i  (en_flat),
      .ir_i       (ir_vec),
      .wr_req_o   (wr_req),
      .wr_en_o    (wr_en),
      .wr_ctl_o   (wr_ctl),
      .rdata_o    (reg_rdata_o)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [SRC_W-1:0] req_g;

      grp_req_bank #(
         .SRC_W (SRC_W)
      ) u_req (
         .clk    (clk),
         .rst    (rst),
         .evt_i  (evt_i[g*SRC_W +: SRC_W]),
         .wr_i   (wr_req[g]),
         .keep_i (reg_wdata_i[DATA_W-1:1]),
         .req_o  (req_g)
      );

      grp_irq_lane #(
         .SRC_W          (SRC_W),
         .SET_OVER_CLEAR (SET_OVER_CLEAR)
      ) u_lane (
         .clk      (clk),
         .rst      (rst),
         .req_i    (req_g),
         .en_wr_i  (wr_en[g]),
         .ctl_wr_i (wr_ctl[g]),
         .wdata_i  (reg_wdata_i),
         .ack_i    (ack_i[g]),
         .en_o     (en_flat[g*DATA_W +: DATA_W]),
         .ir_o     (ir_vec[g])
      );

      assign req_flat[g*SRC_W +: SRC_W]  = req_g;
      assign irq_vec_o[g*VEC_W +: VEC_W] = VEC_W'(VEC_BASE + g);
   end

   assign irq_o = ir_vec;

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (irq_o == '0));                                   // R1

endmodule

// File: tb/test_grp_irq_agg.sv
`timescale 1ns/1ps
module test_grp_irq_agg;

   localparam int NG = 5;
   localparam int SW = 7;
   localparam int DW = 8;
   localparam int AW = 5;
   localparam int VW = 8;

   localparam int K_RD  = 0;
   localparam int K_IRQ = 1;
   localparam int K_VEC = 2;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [NG*SW-1:0] evt = '0;
   logic [NG-1:0]    ack = '0;
   logic [AW-1:0]    addr = '0;
   logic             we = 1'b0;
   logic [DW-1:0]    wdata = '0;
   logic [DW-1:0]    rdata;
   logic [NG-1:0]    irq;
   logic [NG*VW-1:0] vec;

   always #2.5 clk = ~clk;

   grp_irq_agg i_grp_irq_agg (
      .clk         (clk),
      .rst         (rst),
      .evt_i       (evt),
      .ack_i       (ack),
      .reg_addr_i  (addr),
      .reg_we_i    (we),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq),
      .irq_vec_o   (vec)
   );

   typedef struct {
      string       tag;
      int          kind;
      logic [63:0] exp;
      int          due;
   } item_t;

   item_t q[$];
   int    cyc    = 0;
   int    n_chk  = 0;
   int    n_bad  = 0;
   bit    closed = 1'b0;

   // monitor: compares queued expectations at their due negedge
   always @(negedge clk) begin
      item_t       it;
      logic [63:0] act;
      cyc++;
      while (q.size() > 0 && q[0].due <= cyc) begin
         it = q.pop_front();
         case (it.kind)
            K_RD:    act = 64'(rdata);
            K_IRQ:   act = 64'(irq);
            default: act = 64'(vec);
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)",
                     it.tag, act, it.exp, cyc);
         end
      end
   end

   function automatic logic [NG*SW-1:0] ev(input int g, input int j);
      return (NG*SW)'(1) << (g*SW + j);
   endfunction

   task automatic step(input bit w, input int g, input int sel,
                       input logic [DW-1:0] wd, input logic [NG*SW-1:0] e,
                       input logic [NG-1:0] a);
      @(negedge clk);
      #1;
      we    = w;
      addr  = AW'(g*4 + sel);
      wdata = wd;
      evt   = e;
      ack   = a;
   endtask

   task automatic idle();
      step(1'b0, 0, 0, '0, '0, '0);
   endtask

   task automatic wr(input int g, input int sel, input logic [DW-1:0] wd);
      step(1'b1, g, sel, wd, '0, '0);
   endtask

   task automatic expect_at(input string tag, input int kind,
                            input logic [63:0] exp, input int ofs);
      item_t it;
      it.tag  = tag;
      it.kind = kind;
      it.exp  = exp;
      it.due  = cyc + ofs;
      q.push_back(it);
   endtask

   task automatic rd(input int g, input int sel, input logic [DW-1:0] exp,
                     input string tag);
      step(1'b0, g, sel, '0, '0, '0);
      expect_at(tag, K_RD, 64'(exp), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1 rst = 1'b0;

      // reset state
      rd(0, 0, 8'h00, "R1 request g0 after reset");
      rd(2, 1, 8'h00, "R1 enable g2 after reset");
      rd(4, 2, 8'h00, "R1 control g4 after reset");
      expect_at("R1 irq after reset", K_IRQ, 64'h0, 1);
      expect_at("R8 vector numbers", K_VEC,
                64'({8'd48, 8'd47, 8'd46, 8'd45, 8'd44}), 1);

      // group 1: use first, then source 1
      wr(1, 1, 8'h01);
      wr(1, 1, 8'h05);
      rd(1, 1, 8'h05, "R10 enable readback");

      step(1'b0, 0, 0, '0, ev(1, 1), '0);
      expect_at("R4 irq not yet set", K_IRQ, 64'h00, 1);
      expect_at("R4 irq g1 set two edges later", K_IRQ, 64'h02, 2);
      idle(); idle();
      rd(1, 0, 8'h04, "R2 request bit 2 of g1");

      // acknowledge, then a repeated event on a still-set flag
      step(1'b0, 0, 0, '0, '0, 5'b00010);
      expect_at("R7 ack clears irq g1", K_IRQ, 64'h00, 1);
      step(1'b0, 0, 0, '0, ev(1, 1), '0);
      idle(); idle(); idle();
      expect_at("R6 no new irq while combined high", K_IRQ, 64'h00, 1);
      rd(1, 0, 8'h04, "R2 ack leaves request set");

      // software clear, then a new edge; control write 1 then 0
      wr(1, 0, 8'h00);
      rd(1, 0, 8'h00, "R3 request cleared by write of 0");
      step(1'b0, 0, 0, '0, ev(1, 1), '0);
      expect_at("R4 irq g1 after fresh edge", K_IRQ, 64'h02, 2);
      idle(); idle();
      wr(1, 2, 8'h01);
      expect_at("R7 control write 1 no effect", K_IRQ, 64'h02, 1);
      wr(1, 2, 8'h00);
      expect_at("R7 control write 0 clears", K_IRQ, 64'h00, 1);
      rd(1, 2, 8'h00, "R9 control register reads 0");

      // keep-mask write and event-wins collision
      step(1'b0, 0, 0, '0, ev(1, 3), '0);
      rd(1, 0, 8'h14, "R2 second flag set in g1");
      wr(1, 0, 8'h10);
      rd(1, 0, 8'h10, "R3 only 0-written bit cleared");
      step(1'b1, 1, 0, 8'h00, ev(1, 3), '0);
      rd(1, 0, 8'h10, "R3 event wins over clearing write");
      expect_at("R5 disabled source raises no irq", K_IRQ, 64'h00, 1);

      // group 2: sources first with use off, then use on
      wr(2, 1, 8'h02);
      step(1'b0, 0, 0, '0, ev(2, 0), '0);
      idle(); idle(); idle();
      expect_at("R5 use bit 0 blocks irq", K_IRQ, 64'h00, 1);
      rd(2, 0, 8'h02, "R2 request latched with use off");
      wr(2, 1, 8'h03);
      expect_at("R11 no irq before edge", K_IRQ, 64'h00, 1);
      expect_at("R11 use bit on pending request", K_IRQ, 64'h04, 2);
      idle(); idle();

      // group 3: use on but source disabled
      wr(3, 1, 8'h01);
      step(1'b0, 0, 0, '0, ev(3, 2), '0);
      idle(); idle(); idle();
      expect_at("R5 source disabled in g3", K_IRQ, 64'h04, 1);

      // rising edge and acknowledge in one cycle
      wr(2, 0, 8'h00);
      idle();
      step(1'b0, 0, 0, '0, ev(2, 0), '0);
      step(1'b0, 0, 0, '0, '0, 5'b00100);
      expect_at("R7 edge beats ack same cycle", K_IRQ, 64'h04, 1);
      step(1'b0, 0, 0, '0, '0, 5'b00100);
      expect_at("R7 lone ack clears g2", K_IRQ, 64'h00, 1);
      wr(2, 0, 8'hFF);
      rd(2, 0, 8'h02, "R3 write of 1s never sets");

      // groups 0 and 4 together, edge sources at both ends
      wr(0, 1, 8'h01);
      wr(0, 1, 8'h03);
      wr(4, 1, 8'h01);
      wr(4, 1, 8'h81);
      step(1'b0, 0, 0, '0, ev(0, 0) | ev(4, 6), '0);
      expect_at("R4 groups 0 and 4 together", K_IRQ, 64'h11, 2);
      idle(); idle();
      rd(4, 0, 8'h80, "R2 top source of g4");
      rd(0, 0, 8'h02, "R2 bottom source of g0");

      // address map holes
      rd(1, 3, 8'h00, "R9 select 3 reads 0");
      rd(5, 0, 8'h00, "R9 group 5 reads 0");
      rd(7, 1, 8'h00, "R9 group 7 reads 0");
      wr(5, 1, 8'h01);
      rd(0, 1, 8'h03, "R9 write to hole leaves g0 enable");
      expect_at("R9 hole write no irq change", K_IRQ, 64'h11, 1);

      idle(); idle(); idle();
      if (!closed) begin
         closed = 1'b1;
         if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: actual %0d expected 0 pending checks", q.size());
         end
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!closed) begin
         closed = 1'b1;
         n_bad++;
         $display("FAIL watchdog (R1): actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule